// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a first-level data cache with one line per set, backed by a small fully associative victim buffer. A processor issues one word request at a time over a valid/ready handshake. The block looks the address up in both structures at once. On a read hit in the main array it answers on the next cycle. If the block is absent from the main array but present in the victim buffer, the two lines trade places and the answer arrives one cycle later. If the block is absent from both, the whole line is requested from the next memory level and installed, and the line it displaces is moved into the victim buffer.

Victim-buffer entries hold the full block address because the buffer has no index. When the buffer is full, the entry that was least recently inserted or swapped is dropped. Writes go straight through to memory and never allocate a line. Any cached copy of the written word is updated in place, so neither structure ever holds a dirty line and an eviction never needs a write-back.

Top module: `vcache_top`

## Requirements
- R1: A read whose block is valid in the main array raises rspValid exactly one cycle after acceptance, returns the addressed word and issues no memory request.
- R2: A read that misses the main array but matches a victim entry raises rspValid exactly two cycles after acceptance with no memory request. The requested line moves into the main array and the displaced line takes the victim slot, so a block is never held in both structures or twice in the buffer.
- R3: A read that misses both structures raises memReqValid with memReqAddr equal to the word address with its low log2(LINE_WORDS) bits dropped. rspValid rises in the cycle memRspValid is high and returns word k of memRspLine from bits [k*DATA_W +: DATA_W]. The line is then installed in the main array.
- R4: A valid line displaced by a refill is put into the victim buffer, so a later read of it costs two cycles and no fetch.
- R5: A victim insert fills the lowest-numbered empty entry. When no entry is empty, it replaces the entry least recently inserted or swapped. A later read of a replaced block fetches from memory.
- R6: A write raises memWrValid with the word address and data one cycle after acceptance, answers in that same cycle with rspData zero, and allocates nothing: a following read of a block that was absent fetches from memory.
- R7: A write updates the word in whichever structure holds its block, so a later read returns the new value without a fetch.
- R8: Only one request is in flight. reqReady is high only when the block is idle, rspValid is never high together with reqReady, and memReqValid with a stable memReqAddr is held until memReqReady.
- R9: After reset both structures are empty, reqReady is high and rspValid, memReqValid and memWrValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request valid |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W (12) | Word address |
| reqWdata | input | DATA_W (32) | Write data |
| rspValid | output | 1 | Response valid for one cycle |
| rspData | output | DATA_W (32) | Read data, zero for writes |
| memReqValid | output | 1 | Line fetch request |
| memReqReady | input | 1 | Memory accepts the fetch |
| memReqAddr | output | ADDR_W-log2(LINE_WORDS) (10) | Block address to fetch |
| memRspValid | input | 1 | Fetched line valid for one cycle |
| memRspLine | input | DATA_W*LINE_WORDS (128) | Fetched line, word 0 in the low bits |
| memWrValid | output | 1 | Write-through strobe |
| memWrAddr | output | ADDR_W (12) | Word address written |
| memWrData | output | DATA_W (32) | Word written |

## Verification
A single refill cycle does two jobs: it installs the fetched line in the main array and moves the displaced line into the victim buffer, which may also force out the least recently used entry. The bench provokes this with long chains of reads that map to one set. These chains fill the buffer, then a swap-hit refreshes one entry, and the next conflict miss must evict a different one. It judges the outcome by the cost of later reads: the refreshed block must come back in two cycles and the evicted block must cause a fetch. Random traffic on a few conflicting sets with random memory latency repeats this, and an independent model of set contents and age order predicts every latency class and data word.

// File: rtl/vcache_pkg.sv
package vcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_SWAP,
    ST_FETCH,
    ST_WAIT
  } ctrlState_t;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_L1,
    SRC_VB,
    SRC_MEM
  } rspSrc_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    latchReq;
    logic    wordWrite;
    logic    swapLines;
    logic    fillLine;
    rspSrc_t rspSrc;
  } dpStrobe_t;

endpackage

// File: rtl/vcache_lru.sv
module vcache_lru #(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DEPTH-1:0]         entryValid,
  input  logic                     touchEn,
  input  logic [$clog2(DEPTH)-1:0] touchIdx,
  output logic [$clog2(DEPTH)-1:0] victimIdx
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(DEPTH - 1);

  // age 0 = most recent; ages always form a permutation of 0..DEPTH-1
  logic [IDX_W-1:0] age [DEPTH];
  logic [IDX_W-1:0] oldIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) age[i] <= IDX_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IDX_W'(i) == touchIdx) age[i] <= '0;
        else if (age[i] < age[touchIdx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (age[i] == OLDEST) oldIdx = IDX_W'(i);
    end
    victimIdx = oldIdx;
    // an empty slot, lowest index, wins over eviction
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!entryValid[i]) victimIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/vcache_ctrl.sv
module vcache_ctrl
  import vcache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  logic      isWrite,
  input  logic      l1Hit,
  input  logic      vbHit,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output logic      rspValid,
  output logic      memReqValid,
  output logic      memWrValid,
  output dpStrobe_t strobe
);
  ctrlState_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext      = st;
    strobe      = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    memWrValid  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stNext          = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (isWrite) begin
          strobe.wordWrite = 1'b1;
          memWrValid       = 1'b1;
          rspValid         = 1'b1;
          stNext           = ST_IDLE;
        end else if (l1Hit) begin
          strobe.rspSrc = SRC_L1;
          rspValid      = 1'b1;
          stNext        = ST_IDLE;
        end else if (vbHit) begin
          stNext = ST_SWAP;
        end else begin
          stNext = ST_FETCH;
        end
      end
      ST_SWAP: begin
        strobe.swapLines = 1'b1;
        strobe.rspSrc    = SRC_VB;
        rspValid         = 1'b1;
        stNext           = ST_IDLE;
      end
      ST_FETCH: begin
        memReqValid = 1'b1;
        if (memReqReady) stNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.fillLine = 1'b1;
          strobe.rspSrc   = SRC_MEM;
          rspValid        = 1'b1;
          stNext          = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/vcache_dp.sv
module vcache_dp
  import vcache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int L1_SETS    = 8,
  parameter int VB_DEPTH   = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  dpStrobe_t                              strobe,
  input  logic [ADDR_W-1:0]                      reqAddr,
  input  logic                                   reqWrite,
  input  logic [DATA_W-1:0]                      reqWdata,
  input  logic [DATA_W*LINE_WORDS-1:0]           memRspLine,
  output logic                                   isWrite,
  output logic                                   l1Hit,
  output logic                                   vbHit,
  output logic [VB_DEPTH-1:0]                    vbMatch,
  output logic [DATA_W-1:0]                      rspData,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]   memReqAddr,
  output logic [ADDR_W-1:0]                      memWrAddr,
  output logic [DATA_W-1:0]                      memWrData
);
  localparam int OFF_W    = $clog2(LINE_WORDS);
  localparam int IDX_W    = $clog2(L1_SETS);
  localparam int BLK_W    = ADDR_W - OFF_W;
  localparam int TAG_W    = BLK_W - IDX_W;
  localparam int LINE_W   = DATA_W * LINE_WORDS;
  localparam int VB_IDX_W = $clog2(VB_DEPTH);

  // registered request
  logic [ADDR_W-1:0] reqAddrQ;
  logic [DATA_W-1:0] reqWdataQ;
  logic              reqWriteQ;

  // main array
  logic [L1_SETS-1:0] l1Valid;
  logic [TAG_W-1:0]   l1Tag  [L1_SETS];
  logic [LINE_W-1:0]  l1Line [L1_SETS];

  // victim buffer
  logic [VB_DEPTH-1:0] vbValid;
  logic [BLK_W-1:0]    vbBlk  [VB_DEPTH];
  logic [LINE_W-1:0]   vbLine [VB_DEPTH];

  logic [OFF_W-1:0]    curOff;
  logic [IDX_W-1:0]    curIdx;
  logic [TAG_W-1:0]    curTag;
  logic [BLK_W-1:0]    curBlk;
  logic [VB_IDX_W-1:0] hitIdx;
  logic [VB_IDX_W-1:0] victimIdx;
  logic [VB_IDX_W-1:0] touchIdx;
  logic                touchEn;

  function automatic logic [DATA_W-1:0] pickWord(input logic [LINE_W-1:0] line,
                                                 input logic [OFF_W-1:0]  off);
    return line[off*DATA_W +: DATA_W];
  endfunction

  assign curOff = reqAddrQ[OFF_W-1:0];
  assign curIdx = reqAddrQ[OFF_W +: IDX_W];
  assign curTag = reqAddrQ[ADDR_W-1 -: TAG_W];
  assign curBlk = reqAddrQ[ADDR_W-1:OFF_W];

  assign isWrite = reqWriteQ;
  assign l1Hit   = l1Valid[curIdx] && (l1Tag[curIdx] == curTag);

  for (genvar g = 0; g < VB_DEPTH; g++) begin : gMatch
    assign vbMatch[g] = vbValid[g] && (vbBlk[g] == curBlk);
  end
  assign vbHit = |vbMatch;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < VB_DEPTH; i++) begin
      if (vbMatch[i]) hitIdx = VB_IDX_W'(i);
    end
  end

  assign touchEn  = strobe.swapLines || (strobe.fillLine && l1Valid[curIdx]);
  assign touchIdx = strobe.swapLines ? hitIdx : victimIdx;

  vcache_lru #(.DEPTH(VB_DEPTH)) u_lru (
    .clk       (clk),
    .rstN      (rstN),
    .entryValid(vbValid),
    .touchEn   (touchEn),
    .touchIdx  (touchIdx),
    .victimIdx (victimIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      reqWdataQ <= '0;
      reqWriteQ <= 1'b0;
      l1Valid   <= '0;
      vbValid   <= '0;
      for (int i = 0; i < L1_SETS; i++) begin
        l1Tag[i]  <= '0;
        l1Line[i] <= '0;
      end
      for (int i = 0; i < VB_DEPTH; i++) begin
        vbBlk[i]  <= '0;
        vbLine[i] <= '0;
      end
    end else begin
      if (strobe.latchReq) begin
        reqAddrQ  <= reqAddr;
        reqWdataQ <= reqWdata;
        reqWriteQ <= reqWrite;
      end
      // write-through: keep any cached copy current
      if (strobe.wordWrite) begin
        if (l1Hit) l1Line[curIdx][curOff*DATA_W +: DATA_W] <= reqWdataQ;
        if (vbHit) vbLine[hitIdx][curOff*DATA_W +: DATA_W] <= reqWdataQ;
      end
      // exchange the set's line with the matching victim entry
      if (strobe.swapLines) begin
        l1Line[curIdx]  <= vbLine[hitIdx];
        l1Tag[curIdx]   <= curTag;
        l1Valid[curIdx] <= 1'b1;
        vbLine[hitIdx]  <= l1Line[curIdx];
        vbBlk[hitIdx]   <= {l1Tag[curIdx], curIdx};
        vbValid[hitIdx] <= l1Valid[curIdx];
      end
      // refill; displaced line goes to the victim buffer
      if (strobe.fillLine) begin
        l1Line[curIdx]  <= memRspLine;
        l1Tag[curIdx]   <= curTag;
        l1Valid[curIdx] <= 1'b1;
        if (l1Valid[curIdx]) begin
          vbLine[victimIdx]  <= l1Line[curIdx];
          vbBlk[victimIdx]   <= {l1Tag[curIdx], curIdx};
          vbValid[victimIdx] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (strobe.rspSrc)
      SRC_L1:  rspData = pickWord(l1Line[curIdx], curOff);
      SRC_VB:  rspData = pickWord(vbLine[hitIdx], curOff);
      SRC_MEM: rspData = pickWord(memRspLine, curOff);
      default: rspData = '0;
    endcase
  end

  assign memReqAddr = curBlk;
  assign memWrAddr  = reqAddrQ;
  assign memWrData  = reqWdataQ;

endmodule

// File: rtl/vcache_top.sv
module vcache_top
  import vcache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int L1_SETS    = 8,
  parameter int VB_DEPTH   = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  reqValid,
  output logic                                  reqReady,
  input  logic                                  reqWrite,
  input  logic [ADDR_W-1:0]                     reqAddr,
  input  logic [DATA_W-1:0]                     reqWdata,
  output logic                                  rspValid,
  output logic [DATA_W-1:0]                     rspData,
  output logic                                  memReqValid,
  input  logic                                  memReqReady,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]  memReqAddr,
  input  logic                                  memRspValid,
  input  logic [DATA_W*LINE_WORDS-1:0]          memRspLine,
  output logic                                  memWrValid,
  output logic [ADDR_W-1:0]                     memWrAddr,
  output logic [DATA_W-1:0]                     memWrData
);
  localparam int BLK_W = ADDR_W - $clog2(LINE_WORDS);

  dpStrobe_t           strobe;
  logic                isWrite;
  logic                l1Hit;
  logic                vbHit;
  logic [VB_DEPTH-1:0] vbMatch;

  vcache_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .isWrite    (isWrite),
    .l1Hit      (l1Hit),
    .vbHit      (vbHit),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .rspValid   (rspValid),
    .memReqValid(memReqValid),
    .memWrValid (memWrValid),
    .strobe     (strobe)
  );

  vcache_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LINE_WORDS(LINE_WORDS),
    .L1_SETS   (L1_SETS),
    .VB_DEPTH  (VB_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .memRspLine(memRspLine),
    .isWrite   (isWrite),
    .l1Hit     (l1Hit),
    .vbHit     (vbHit),
    .vbMatch   (vbMatch),
    .rspData   (rspData),
    .memReqAddr(memReqAddr),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData)
  );

endmodule

// File: rtl/vcache_chk.sv
module vcache_chk #(
  parameter int VB_DEPTH = 4,
  parameter int BLK_W    = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic                reqWrite,
  input logic                rspValid,
  input logic                memReqValid,
  input logic                memReqReady,
  input logic [BLK_W-1:0]    memReqAddr,
  input logic                memWrValid,
  input logic                l1Hit,
  input logic                vbHit,
  input logic [VB_DEPTH-1:0] vbMatch
);
  logic lookQ;
  logic writeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lookQ  <= 1'b0;
      writeQ <= 1'b0;
    end else begin
      lookQ <= reqValid && reqReady;
      if (reqValid && reqReady) writeQ <= reqWrite;
    end
  end

  AST_L1_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lookQ && !writeQ && l1Hit |-> rspValid && !memReqValid);                 // R1
  AST_VB_HIT_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    lookQ && !writeQ && !l1Hit && vbHit |-> !rspValid && !memReqValid);      // R2
  AST_VB_HIT_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lookQ && !writeQ && !l1Hit && vbHit |=> rspValid && !memReqValid);       // R2
  AST_NO_DUAL_RESIDENCE: assert property (@(posedge clk) disable iff (!rstN)
    !(l1Hit && vbHit));                                                      // R2
  AST_VB_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vbMatch));                                                      // R2
  AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (!rstN)
    lookQ && !writeQ && !l1Hit && !vbHit |=> memReqValid);                   // R3
  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    lookQ && writeQ |-> memWrValid && rspValid && !memReqValid);             // R6
  AST_RSP_NOT_WHILE_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);                                                 // R8
  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));     // R8

endmodule

bind vcache_top vcache_chk #(
  .VB_DEPTH(VB_DEPTH),
  .BLK_W   (BLK_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqWrite   (reqWrite),
  .rspValid   (rspValid),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr),
  .memWrValid (memWrValid),
  .l1Hit      (l1Hit),
  .vbHit      (vbHit),
  .vbMatch    (vbMatch)
);

// File: tb/vcache_top_tb.sv
`timescale 1ns/1ps
module vcache_top_tb;
  localparam int ADDR_W = 12, DATA_W = 32, LINE_WORDS = 4, L1_SETS = 8, VB_DEPTH = 4;
  localparam int BLK_W = 10, LINE_W = 128, MEM_WORDS = 4096;
  localparam int CLS_L1 = 0, CLS_VB = 1, CLS_MEM = 2, CLS_BAD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic reqReady, rspValid, memReqValid, memWrValid;
  logic [DATA_W-1:0] rspData, memWrData;
  logic [BLK_W-1:0] memReqAddr;
  logic [ADDR_W-1:0] memWrAddr;
  logic memReqReady = 1'b0, memRspValid = 1'b0;
  logic [LINE_W-1:0] memRspLine = '0;

  always #2.5 clk = ~clk;

  vcache_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspLine(memRspLine), .memWrValid(memWrValid), .memWrAddr(memWrAddr),
    .memWrData(memWrData));

  logic [31:0] memArr [MEM_WORDS];
  logic [31:0] refMem [MEM_WORDS];
  int nChecks = 0, nFails = 0;
  int cntL1 = 0, cntVb = 0, cntMem = 0;
  bit done = 0;

  // independent model of residency and age order
  bit mL1Valid [L1_SETS];
  int mL1Blk   [L1_SETS];
  bit mVbValid [VB_DEPTH];
  int mVbBlk   [VB_DEPTH];
  int mVbAge   [VB_DEPTH];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  function automatic logic [LINE_W-1:0] buildLine(input int blk);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < LINE_WORDS; k++) l[k*DATA_W +: DATA_W] = memArr[blk*LINE_WORDS + k];
    return l;
  endfunction

  task automatic touch(input int e);
    for (int j = 0; j < VB_DEPTH; j++)
      if (j != e && mVbAge[j] < mVbAge[e]) mVbAge[j]++;
    mVbAge[e] = 0;
  endtask

  task automatic modelRead(input int blk, output int cls);
    int set, hit, v, tb;
    bit tv;
    set = blk % L1_SETS;
    if (mL1Valid[set] && mL1Blk[set] == blk) begin
      cls = CLS_L1;
    end else begin
      hit = -1;
      for (int i = 0; i < VB_DEPTH; i++) if (mVbValid[i] && mVbBlk[i] == blk) hit = i;
      if (hit >= 0) begin
        cls = CLS_VB;
        tb = mL1Blk[set]; tv = mL1Valid[set];
        mVbBlk[hit] = tb; mVbValid[hit] = tv;
        touch(hit);
      end else begin
        cls = CLS_MEM;
        if (mL1Valid[set]) begin
          v = -1;
          for (int i = VB_DEPTH - 1; i >= 0; i--) if (!mVbValid[i]) v = i;
          if (v < 0) for (int i = 0; i < VB_DEPTH; i++) if (mVbAge[i] == VB_DEPTH - 1) v = i;
          mVbBlk[v] = mL1Blk[set]; mVbValid[v] = 1;
          touch(v);
        end
      end
      mL1Blk[set] = blk; mL1Valid[set] = 1;
    end
  endtask

  // memory model: drives just after each rising edge
  initial begin
    int cnt;
    bit pend;
    int pendBlk;
    pend = 0; cnt = 0; pendBlk = 0;
    forever begin
      @(posedge clk); #1;
      memRspValid = 1'b0;
      if (memWrValid) memArr[memWrAddr] = memWrData;
      if (pend) begin
        if (cnt == 0) begin
          memRspValid = 1'b1;
          memRspLine  = buildLine(pendBlk);
          pend = 0;
        end else cnt--;
      end
      memReqReady = ($urandom % 4) != 0;
      if (!pend && !memRspValid && memReqValid && memReqReady) begin
        pend = 1; pendBlk = int'(memReqAddr); cnt = $urandom % 3;
      end
    end
  end

  // one access; expCls < 0 takes the model's prediction
  task automatic access(input bit wr, input int addr, input logic [31:0] wdata,
                        input int expCls, input string req);
    int blk, cls, lat, obs, guard;
    bit sawMem, addrOk;
    blk = addr / LINE_WORDS;
    if (wr) cls = CLS_L1; else modelRead(blk, cls);
    if (expCls >= 0) cls = expCls;
    @(negedge clk);
    guard = 0;
    while (!reqReady && guard < 50) begin @(negedge clk); guard++; end
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(addr); reqWdata = wdata;
    if (wr) refMem[addr] = wdata;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1; sawMem = 0; addrOk = 1;
    while (!rspValid && lat < 60) begin
      if (memReqValid) begin
        sawMem = 1;
        if (int'(memReqAddr) != blk) addrOk = 0;
      end
      @(negedge clk);
      lat++;
    end
    if (!rspValid) begin
      nChecks++; nFails++;
      $display("FAIL %s response timeout: actual none expected rspValid", req);
      return;
    end
    chk("R8", "reqReady during response", 32'(reqReady), 32'd0);
    if (sawMem) chk("R3", "fetch block address held", 32'(addrOk), 32'd1);
    if (lat == 1) obs = CLS_L1;
    else if (lat == 2 && !sawMem) obs = CLS_VB;
    else if (sawMem) obs = CLS_MEM;
    else obs = CLS_BAD;
    if (wr) begin
      chk(req, "write latency class", 32'(obs), 32'(CLS_L1));
      chk(req, "write-through strobe", 32'(memWrValid), 32'd1);
      chk(req, "write-through address", 32'(memWrAddr), 32'(addr));
      chk(req, "write-through data", memWrData, wdata);
      chk(req, "write response data", rspData, 32'd0);
    end else begin
      chk(req, "read latency class", 32'(obs), 32'(cls));
      chk(req, "read data", rspData, refMem[addr]);
      if (obs == CLS_L1) cntL1++;
      else if (obs == CLS_VB) cntVb++;
      else if (obs == CLS_MEM) cntMem++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < MEM_WORDS; i++) begin
      memArr[i] = (i * 32'h01000193) ^ 32'hC0DE0000;
      refMem[i] = memArr[i];
    end
    for (int i = 0; i < L1_SETS; i++) begin mL1Valid[i] = 0; mL1Blk[i] = 0; end
    for (int i = 0; i < VB_DEPTH; i++) begin mVbValid[i] = 0; mVbBlk[i] = 0; mVbAge[i] = i; end

    repeat (4) @(negedge clk);
    // R9: idle outputs during and just after reset
    chk("R9", "reqReady in reset", 32'(reqReady), 32'd1);
    chk("R9", "rspValid in reset", 32'(rspValid), 32'd0);
    chk("R9", "memReqValid in reset", 32'(memReqValid), 32'd0);
    chk("R9", "memWrValid in reset", 32'(memWrValid), 32'd0);
    rstN = 1'b1;

    // directed conflict chain on set 0 (blocks 0,8,16,24,32,40)
    access(0, 0,   '0, CLS_MEM, "R9");  // empty after reset
    access(0, 1,   '0, CLS_L1,  "R1");
    access(0, 32,  '0, CLS_MEM, "R3");
    access(0, 2,   '0, CLS_VB,  "R4");  // displaced block sits in buffer
    access(0, 33,  '0, CLS_VB,  "R2");
    access(0, 35,  '0, CLS_L1,  "R2");  // swapped line now in main array
    access(0, 64,  '0, CLS_MEM, "R3");
    access(0, 96,  '0, CLS_MEM, "R3");
    access(0, 128, '0, CLS_MEM, "R5");  // buffer now full
    access(0, 34,  '0, CLS_VB,  "R5");  // refreshes block 8 entry
    access(0, 160, '0, CLS_MEM, "R5");  // evicts oldest: block 0
    access(0, 3,   '0, CLS_MEM, "R5");  // evicted block refetched
    access(0, 129, '0, CLS_VB,  "R5");  // refreshed block survived
    access(0, 65,  '0, CLS_MEM, "R5");
    access(1, 66,  32'hA5A50001, -1, "R6");
    access(0, 66,  '0, CLS_L1,  "R7");
    access(1, 33,  32'h5A5A0002, -1, "R7");  // block 8 lives in buffer
    access(0, 33,  '0, CLS_VB,  "R7");
    access(1, 400, 32'h0BADF00D, -1, "R6");
    access(0, 400, '0, CLS_MEM, "R6");  // no allocation on write

    chk("R1", "directed main-array hits", 32'(cntL1), 32'd3);
    chk("R2", "directed victim hits", 32'(cntVb), 32'd5);
    chk("R3", "directed fetches", 32'(cntMem), 32'd9);

    // random conflict traffic on four sets
    for (int n = 0; n < 400; n++) begin
      int set, tag, off, addr, cls;
      bit wr;
      set = $urandom % 4; tag = $urandom % 6; off = $urandom % 4;
      addr = ((tag * L1_SETS + set) * LINE_WORDS) + off;
      wr = ($urandom % 4) == 0;
      if (wr) access(1, addr, $urandom, -1, "R6");
      else begin
        // peek the prediction without disturbing the model
        cls = -1;
        if (mL1Valid[(addr/4) % L1_SETS] && mL1Blk[(addr/4) % L1_SETS] == addr/4) cls = CLS_L1;
        else for (int i = 0; i < VB_DEPTH; i++) if (mVbValid[i] && mVbBlk[i] == addr/4) cls = CLS_VB;
        access(0, addr, '0, -1, cls == CLS_L1 ? "R1" : (cls == CLS_VB ? "R2" : "R3"));
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule